// File: doc/BRIEF.md
# Unified Read/Write Address Queue Front End

This block accepts requests from two independent address channels, one carrying read requests and one carrying write requests, and funnels both into a single in-order queue of twelve entries. Each channel uses a VALID/READY handshake. When both channels offer a request in the same cycle, a two-way round-robin arbiter picks one. The other channel sees READY low and holds its request.

Every queued entry records the request address, its transaction ID and a direction bit, so that a downstream scheduler can tell reads from writes and route data and responses. The downstream consumer sees the oldest entry at the queue head and removes it with a pop strobe. The block reports the queue occupancy and a full flag. In a single cycle one request can enter and one entry can leave.

Top module: `addr_merge_top`

## Requirements
- R1: A request is taken from a channel only in a cycle where that channel's VALID and READY are both high. READY is never high while that channel's VALID is low.
- R2: The head of the queue shows the entries in acceptance order, each carrying the accepted address and ID. The direction bit `q_is_write_o` is 1 for an entry from the write channel and 0 for an entry from the read channel. `q_valid_o` is high whenever the queue holds at least one entry.
- R3: The queue holds at most 12 entries. `q_count_o` gives the number held. `q_full_o` is high exactly when the count is 12.
- R4: While the queue is full, both READY outputs are low, even in a cycle where a pop is requested.
- R5: When only one channel is valid and the queue is not full, that channel's READY is high in the same cycle.
- R6: When both channels are valid and the queue is not full, exactly one channel is granted. The grant goes to the channel that was not granted most recently. The first such contention after reset goes to the read channel.
- R7: The round-robin turn changes only on an accepted grant. Idle cycles, and cycles in which both channels are refused because the queue is full, leave the turn unchanged.
- R8: A cycle with an accepted request and a pop of a non-empty queue leaves the count unchanged.
- R9: A pop while the queue is empty has no effect. The count stays 0 and `q_valid_o` stays low.
- R10: After reset the queue is empty, `q_full_o` is low and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ar_valid_i | input | 1 | Read request valid |
| ar_ready_o | output | 1 | Read request accepted this cycle |
| ar_addr_i | input | ADDR_W | Read request address |
| ar_id_i | input | ID_W | Read request ID |
| aw_valid_i | input | 1 | Write request valid |
| aw_ready_o | output | 1 | Write request accepted this cycle |
| aw_addr_i | input | ADDR_W | Write request address |
| aw_id_i | input | ID_W | Write request ID |
| q_valid_o | output | 1 | Queue head holds an entry |
| q_addr_o | output | ADDR_W | Address at queue head |
| q_id_o | output | ID_W | ID at queue head |
| q_is_write_o | output | 1 | Direction at queue head: 1 write, 0 read |
| q_pop_i | input | 1 | Remove the head entry |
| q_count_o | output | CNT_W | Number of queued entries |
| q_full_o | output | 1 | Queue holds 12 entries |

## Verification
The stimulus starts with a read-only stream. This shows that a lone channel is granted every cycle and that entries keep their order. Next comes continuous two-channel contention with pops. This separates strict alternation from a fixed priority and confirms that the count holds steady when a request enters and an entry leaves in the same cycle. A fill phase with both channels held valid while the queue is full, followed by idle gaps, shows that neither a blocked cycle nor an idle cycle shifts the turn. Finally, a long sweep through every combination of the two valid inputs and the pop input, including pops on an empty queue, is compared against an arithmetic model of the queue and the turn.

// File: rtl/addr_merge_pkg.sv
package addr_merge_pkg;
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;

  localparam int unsigned DEF_DEPTH  = 12;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_ID_W   = 4;
endpackage

// File: rtl/am_rr_arb2.sv
module am_rr_arb2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_rd_i,
  input  logic req_wr_i,
  input  logic room_i,
  output logic gnt_rd_o,
  output logic gnt_wr_o
);
  // last_wr_q: 1 when the most recent accepted grant went to the write side
  logic last_wr_q;

  always_comb begin
    gnt_rd_o = 1'b0;
    gnt_wr_o = 1'b0;
    if (room_i) begin
      if (req_rd_i && req_wr_i) begin
        if (last_wr_q) gnt_rd_o = 1'b1;
        else           gnt_wr_o = 1'b1;
      end else begin
        gnt_rd_o = req_rd_i;
        gnt_wr_o = req_wr_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_wr_q <= 1'b1;
    else if (gnt_rd_o) last_wr_q <= 1'b0;
    else if (gnt_wr_o) last_wr_q <= 1'b1;
  end

  p_one_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gnt_rd_o, gnt_wr_o}));

  p_alternate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(gnt_rd_o) && req_rd_i && req_wr_i && room_i) |-> gnt_wr_o);

  p_lone_rd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (room_i && req_rd_i && !req_wr_i) |-> gnt_rd_o);

  p_lone_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (room_i && req_wr_i && !req_rd_i) |-> gnt_wr_o);

  p_no_room_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !room_i |-> !(gnt_rd_o || gnt_wr_o));
endmodule

// File: rtl/am_fifo.sv
module am_fifo #(
  parameter int unsigned WIDTH = 37,
  parameter int unsigned DEPTH = 12,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign count_o = cnt_q;
  assign data_o  = mem_q[rd_ptr_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_ok && wr_ptr_q == PTR_W'(g)) mem_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  p_push_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty_o && !full_o) |=> (count_o == $past(count_o)));

  p_pop_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/addr_merge_top.sv
module addr_merge_top
  import addr_merge_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned ID_W   = DEF_ID_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned ENT_W = 1 + ID_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ar_valid_i,
  output logic              ar_ready_o,
  input  logic [ADDR_W-1:0] ar_addr_i,
  input  logic [ID_W-1:0]   ar_id_i,
  input  logic              aw_valid_i,
  output logic              aw_ready_o,
  input  logic [ADDR_W-1:0] aw_addr_i,
  input  logic [ID_W-1:0]   aw_id_i,
  output logic              q_valid_o,
  output logic [ADDR_W-1:0] q_addr_o,
  output logic [ID_W-1:0]   q_id_o,
  output logic              q_is_write_o,
  input  logic              q_pop_i,
  output logic [CNT_W-1:0]  q_count_o,
  output logic              q_full_o
);
  logic             gnt_rd, gnt_wr, empty;
  logic [ENT_W-1:0] ent_in, ent_out;
  dir_e             dir_in;

  am_rr_arb2 i_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_rd_i (ar_valid_i),
    .req_wr_i (aw_valid_i),
    .room_i   (!q_full_o),
    .gnt_rd_o (gnt_rd),
    .gnt_wr_o (gnt_wr)
  );

  assign dir_in = gnt_wr ? DIR_WRITE : DIR_READ;
  assign ent_in = gnt_wr ? {dir_in, aw_id_i, aw_addr_i}
                         : {dir_in, ar_id_i, ar_addr_i};

  am_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (gnt_rd || gnt_wr),
    .data_i  (ent_in),
    .pop_i   (q_pop_i),
    .data_o  (ent_out),
    .count_o (q_count_o),
    .full_o  (q_full_o),
    .empty_o (empty)
  );

  assign ar_ready_o   = gnt_rd;
  assign aw_ready_o   = gnt_wr;
  assign q_valid_o    = !empty;
  assign q_addr_o     = ent_out[ADDR_W-1:0];
  assign q_id_o       = ent_out[ADDR_W +: ID_W];
  assign q_is_write_o = ent_out[ENT_W-1];

  p_rd_ready_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_ready_o |-> ar_valid_i);

  p_wr_ready_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_ready_o |-> aw_valid_i);

  p_full_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_full_o |-> !(ar_ready_o || aw_ready_o));

  p_full_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_full_o |-> (q_count_o == CNT_W'(DEPTH)));

  p_accept_grows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ar_ready_o || aw_ready_o) && !q_pop_i) |=> (q_count_o == $past(q_count_o) + CNT_W'(1)));
endmodule

// File: tb/test_addr_merge_top.sv
`timescale 1ns/1ps
module test_addr_merge_top;
  localparam int DEPTH = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ar_valid_i = 1'b0, aw_valid_i = 1'b0, q_pop_i = 1'b0;
  logic [31:0] ar_addr_i = '0, aw_addr_i = '0;
  logic [3:0]  ar_id_i = '0, aw_id_i = '0;
  logic        ar_ready_o, aw_ready_o, q_valid_o, q_is_write_o, q_full_o;
  logic [31:0] q_addr_o;
  logic [3:0]  q_id_o;
  logic [3:0]  q_count_o;

  addr_merge_top i_addr_merge_top (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ar_valid_i(ar_valid_i), .ar_ready_o(ar_ready_o), .ar_addr_i(ar_addr_i), .ar_id_i(ar_id_i),
    .aw_valid_i(aw_valid_i), .aw_ready_o(aw_ready_o), .aw_addr_i(aw_addr_i), .aw_id_i(aw_id_i),
    .q_valid_o(q_valid_o), .q_addr_o(q_addr_o), .q_id_o(q_id_o), .q_is_write_o(q_is_write_o),
    .q_pop_i(q_pop_i), .q_count_o(q_count_o), .q_full_o(q_full_o)
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, seq = 0;
  bit done = 0;
  string rdy_tag = "", cnt_tag = "";
  logic [31:0] m_addr[$];
  logic [3:0]  m_id[$];
  logic        m_wr[$];
  logic        m_last_wr = 1'b1;  // R6: first contention after reset goes to read

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // one clock cycle: drive, check combinational outputs, advance, update model
  task automatic cyc(input logic arv, input logic awv, input logic pop);
    logic room, g_rd, g_wr;
    string rt, ct;
    ar_valid_i = arv; aw_valid_i = awv; q_pop_i = pop;
    ar_addr_i = 32'h1000_0000 + 32'(seq);
    ar_id_i   = 4'(seq);
    aw_addr_i = 32'h2000_0000 + 32'(seq * 3);
    aw_id_i   = ~4'(seq);
    seq++;
    #2;
    room = (m_addr.size() < DEPTH);
    g_rd = 0; g_wr = 0;
    if (room) begin
      if (arv && awv) begin g_rd = m_last_wr; g_wr = !m_last_wr; end
      else begin g_rd = arv; g_wr = awv; end
    end
    rt = (rdy_tag != "") ? rdy_tag : (!room ? "R4" : ((arv && awv) ? "R6" : "R5"));
    ct = (cnt_tag != "") ? cnt_tag : "R3";
    chk({rt, " ar_ready"}, 64'(ar_ready_o), 64'(g_rd));
    chk({rt, " aw_ready"}, 64'(aw_ready_o), 64'(g_wr));
    chk({ct, " count"}, 64'(q_count_o), 64'(m_addr.size()));
    chk("R3 full", 64'(q_full_o), 64'(!room));
    chk("R2 valid", 64'(q_valid_o), 64'(m_addr.size() != 0));
    if (m_addr.size() != 0) begin
      chk("R1/R2 addr", 64'(q_addr_o), 64'(m_addr[0]));
      chk("R1/R2 id", 64'(q_id_o), 64'(m_id[0]));
      chk("R2 dir", 64'(q_is_write_o), 64'(m_wr[0]));
    end
    @(posedge clk_i);
    if (pop && m_addr.size() != 0) begin
      void'(m_addr.pop_front()); void'(m_id.pop_front()); void'(m_wr.pop_front());
    end
    if (g_rd) begin
      m_addr.push_back(ar_addr_i); m_id.push_back(ar_id_i); m_wr.push_back(1'b0); m_last_wr = 1'b0;
    end
    if (g_wr) begin
      m_addr.push_back(aw_addr_i); m_id.push_back(aw_id_i); m_wr.push_back(1'b1); m_last_wr = 1'b1;
    end
    #1;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R10 count", 64'(q_count_o), 64'd0);
    chk("R10 valid", 64'(q_valid_o), 64'd0);
    chk("R10 full", 64'(q_full_o), 64'd0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R9: pops on empty queue
    cnt_tag = "R9";
    repeat (3) cyc(0, 0, 1);
    cnt_tag = "";

    // R5: read-only stream
    repeat (5) cyc(1, 0, 0);
    // R6/R8: contention with pops
    cnt_tag = "R8";
    repeat (20) cyc(1, 1, 1);
    cnt_tag = "";
    // fill to full, then hold contention while full (R4, R7)
    repeat (10) cyc(1, 1, 0);
    rdy_tag = "R7";
    repeat (4) cyc(1, 1, 0);
    cyc(0, 0, 1);
    cyc(1, 1, 0);
    repeat (3) cyc(0, 0, 1);
    repeat (3) cyc(0, 0, 0);
    cyc(1, 1, 0);
    rdy_tag = "";
    // drain under write-only stream, then empty out
    repeat (6) cyc(0, 1, 1);
    repeat (16) cyc(0, 0, 1);

    // sweep over all valid/pop combinations
    for (int i = 0; i < 3000; i++) begin
      int p;
      p = (i * 5 + i / 7 + (i / 64) * 3) % 8;
      if (i % 400 < 100) p = p | 3;  // bias toward filling
      cyc(p[0], p[1], p[2]);
    end
    repeat (14) cyc(0, 0, 1);
    summary();
  end
endmodule